// File: doc/BRIEF.md
# Outstanding Request Tracker with Deadline Timeout

This block keeps a record of every outbound read, and every write that needs an acknowledgement, from the moment it is issued until the matching response comes back. On acceptance each tracked request is given a tag from one of two fixed pools, one for reads and one for acknowledged writes. The block stores the caller's payload reference and a deadline next to the tag. The deadline is the programmed timeout span added to a shared free-running cycle counter. Because of this, no entry needs a countdown timer of its own.

Responses are matched to entries by tag. A good response to a read returns its data and completes it. A retry response asks the transmit path to send the same request again and starts a new deadline. An error response, or a deadline that is reached, reports an error to the slave side. Writes that need no acknowledgement pass through without taking a tag. When a pool is empty, new requests of that kind are held off with a stall signal. Responses whose tag matches no live entry are dropped and flagged.

Top module: `req_tracker`

## Requirements
- R1: Read tags are 0 to 13 and acknowledged-write tags are 14 to 25. An accepted request takes the lowest free tag of its pool, shown on `iss_tag` in the same cycle. When that pool has no free tag, `iss_stall` is high while such a request is offered, and the request is not taken.
- R2: Kind codes are 0 for read, 1 for a write needing an acknowledgement, 2 for a posted write and 3 for a streaming write. Kinds 2 and 3 never stall, take no tag and never produce a completion or error pulse.
- R3: On acceptance the deadline is the counter value plus `tmo_cfg`, taken modulo 2^CNT_W. The entry is retired as timed out when the counter equals the deadline. With a span T of 1 or more, the error pulse of the entry's side (`rd_err` or `wr_err`, carrying the entry's reference) appears T clock edges after the accepting edge, provided no other event holds that side.
- R4: Status code 0 for a live read tag gives a one-cycle `rd_done` on the edge after the response. `rd_data` equals the response data and `rd_ref` equals the stored reference. The tag is then free.
- R5: Status code 1 (retry) for a live tag gives a one-cycle `resend` on the next edge, carrying the tag and the stored reference. The entry stays live and its deadline is recomputed from the counter value at the retry.
- R6: Status codes 2 and 3 for a live read tag give a one-cycle `rd_err` with `rd_ref`. For a live write tag they give `wr_err` with `wr_ref`. The tag is then free.
- R7: Status code 0 for a live write tag gives a one-cycle `wr_done` with `wr_ref` on the next edge, and the tag is then free.
- R8: A response whose tag is 26 or above, or belongs to no live entry, raises `rsp_unexp` for one cycle on the next edge and produces no other pulse.
- R9: Entries of one pool that become due in the same cycle are retired one per cycle, lowest tag first, and none is lost. A response to a live entry of that pool takes priority over a retirement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_cfg | input | CNT_W | Timeout span added to the counter at issue and at retry |
| iss_valid | input | 1 | A request is offered |
| iss_kind | input | 2 | Request kind code (R2) |
| iss_ref | input | REF_W | Caller's payload reference |
| iss_stall | output | 1 | Offered request cannot be taken this cycle |
| iss_tag | output | TAG_W | Tag that the offered request receives |
| rsp_valid | input | 1 | A response is present |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_status | input | 2 | Response status code |
| rsp_data | input | DATA_W | Read payload of the response |
| rd_done | output | 1 | Read completed |
| rd_err | output | 1 | Read failed or timed out |
| rd_data | output | DATA_W | Read data on completion |
| rd_ref | output | REF_W | Reference of the finished read |
| wr_done | output | 1 | Acknowledged write completed |
| wr_err | output | 1 | Acknowledged write failed or timed out |
| wr_ref | output | REF_W | Reference of the finished write |
| resend | output | 1 | Request must be sent again |
| resend_tag | output | TAG_W | Tag to send again |
| resend_ref | output | REF_W | Reference to send again |
| rsp_unexp | output | 1 | Response dropped, no live tag matched |

## Verification
The bench fills both pools to the brim and checks that the stall appears only for the full kind, while posted writes still pass. A design that shared one pool, or stalled every kind, would fail here. It measures the exact edge of a timeout, and of a timeout whose deadline was renewed by a retry. An off-by-one deadline, or a refresh that kept the old deadline, shows up as a misplaced error pulse. Two reads are made due in the same cycle to catch a design that drops one of them or retires them out of order. Random traffic with stray and stale tags catches mismatched references, lost data and unflagged bogus responses.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
  typedef enum logic [1:0] {
    K_READ         = 2'd0,
    K_WRITE_ACK    = 2'd1,
    K_WRITE_POST   = 2'd2,
    K_WRITE_STREAM = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_DONE  = 2'd0,
    S_RETRY = 2'd1,
    S_ERROR = 2'd2,
    S_FAULT = 2'd3
  } status_e;

  // Only reads and acknowledged writes occupy a tag.
  function automatic logic is_tracked(input logic [1:0] kind);
    return (kind == K_READ) || (kind == K_WRITE_ACK);
  endfunction

  function automatic logic is_failure(input logic [1:0] status);
    return status[1];
  endfunction
endpackage

// File: rtl/rt_tick.sv
`timescale 1ns/1ps
module rt_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end
endmodule

// File: rtl/rt_pick.sv
`timescale 1ns/1ps
module rt_pick #(
  parameter int N  = 14,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rt_pool.sv
`timescale 1ns/1ps
module rt_pool #(
  parameter int SLOTS = 14,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int CNT_W = 16,
  parameter int REF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now,
  input  logic [CNT_W-1:0] tmo,
  input  logic             alloc_en,
  input  logic [REF_W-1:0] alloc_ref,
  output logic             free_ok,
  output logic [IDX_W-1:0] free_idx,
  input  logic             rsp_en,
  input  logic [IDX_W-1:0] rsp_idx,
  input  logic             rsp_retry,
  output logic             rsp_known,
  output logic [REF_W-1:0] rsp_ref,
  output logic             to_fire,
  output logic [IDX_W-1:0] to_idx,
  output logic [REF_W-1:0] to_ref
);
  // Deadline arithmetic: modular sum, so a wrapped counter still meets it.
  function automatic logic [CNT_W-1:0] deadline_of(input logic [CNT_W-1:0] base,
                                                   input logic [CNT_W-1:0] span);
    return base + span;
  endfunction

  logic [SLOTS-1:0] busy_q;
  logic [SLOTS-1:0] due_hit;
  logic [SLOTS-1:0] late_now;
  logic [SLOTS-1:0] alloc_vec;
  logic [SLOTS-1:0] hit_vec;
  logic [SLOTS-1:0] close_vec;
  logic [SLOTS-1:0] renew_vec;
  logic [REF_W-1:0] ref_arr [SLOTS];
  logic             late_any;

  rt_pick #(.N(SLOTS), .IW(IDX_W)) u_free (
    .req (~busy_q),
    .any (free_ok),
    .idx (free_idx)
  );

  rt_pick #(.N(SLOTS), .IW(IDX_W)) u_late (
    .req (late_now),
    .any (late_any),
    .idx (to_idx)
  );

  assign rsp_known = rsp_en && busy_q[rsp_idx];
  assign rsp_ref   = ref_arr[rsp_idx];
  // A response to this pool owns the result port; the due entry waits.
  assign to_fire   = late_any && !rsp_known;
  assign to_ref    = ref_arr[to_idx];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             busy_r;
    logic             late_r;
    logic [CNT_W-1:0] due_r;
    logic [REF_W-1:0] ref_r;

    assign busy_q[g]    = busy_r;
    assign ref_arr[g]   = ref_r;
    assign due_hit[g]   = busy_r && (due_r == now);
    assign late_now[g]  = busy_r && (late_r || due_hit[g]);
    assign alloc_vec[g] = alloc_en && free_ok && (free_idx == IDX_W'(g));
    assign hit_vec[g]   = rsp_known && (rsp_idx == IDX_W'(g));
    assign close_vec[g] = (hit_vec[g] && !rsp_retry) ||
                          (to_fire && (to_idx == IDX_W'(g)));
    assign renew_vec[g] = hit_vec[g] && rsp_retry;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        late_r <= 1'b0;
        due_r  <= '0;
        ref_r  <= '0;
      end else if (alloc_vec[g]) begin
        busy_r <= 1'b1;
        late_r <= 1'b0;
        due_r  <= deadline_of(now, tmo);
        ref_r  <= alloc_ref;
      end else if (close_vec[g]) begin
        busy_r <= 1'b0;
        late_r <= 1'b0;
      end else if (renew_vec[g]) begin
        late_r <= 1'b0;
        due_r  <= deadline_of(now, tmo);
      end else if (late_now[g]) begin
        late_r <= 1'b1;
      end
    end

    AST_CLOSE_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      close_vec[g] |-> busy_r); // R9
    AST_DUE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (due_hit[g] && !close_vec[g] && !renew_vec[g]) |=> (busy_r && late_r)); // R3
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_ok); // R1
endmodule

// File: rtl/req_tracker.sv
`timescale 1ns/1ps
module req_tracker
  import rt_pkg::*;
#(
  parameter int RD_SLOTS = 14,
  parameter int WR_SLOTS = 12,
  parameter int CNT_W    = 16,
  parameter int REF_W    = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = $clog2(RD_SLOTS + WR_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tmo_cfg,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [REF_W-1:0]  iss_ref,
  output logic              iss_stall,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [1:0]        rsp_status,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_done,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic [REF_W-1:0]  rd_ref,
  output logic              wr_done,
  output logic              wr_err,
  output logic [REF_W-1:0]  wr_ref,
  output logic              resend,
  output logic [TAG_W-1:0]  resend_tag,
  output logic [REF_W-1:0]  resend_ref,
  output logic              rsp_unexp
);
  localparam int TOTAL = RD_SLOTS + WR_SLOTS;
  localparam int RD_IW = $clog2(RD_SLOTS);
  localparam int WR_IW = $clog2(WR_SLOTS);
  localparam logic [TAG_W-1:0] WR_BASE = TAG_W'(RD_SLOTS);
  localparam logic [TAG_W-1:0] TAG_END = TAG_W'(TOTAL);

  logic [CNT_W-1:0] now;
  logic             want_rd, want_wr;
  logic             rd_free_ok, wr_free_ok;
  logic [RD_IW-1:0] rd_free_idx, rd_rsp_idx, rd_to_idx;
  logic [WR_IW-1:0] wr_free_idx, wr_rsp_idx, wr_to_idx;
  logic             rd_alloc, wr_alloc;
  logic             rsp_to_rd, rsp_to_wr, rsp_retry;
  logic             rd_known, wr_known, any_known;
  logic [REF_W-1:0] rd_rsp_ref, wr_rsp_ref, rd_to_ref, wr_to_ref;
  logic             rd_to_fire, wr_to_fire;

  rt_tick #(.CNT_W(CNT_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (now)
  );

  // Issue side: pool selection and hold-off.
  assign want_rd   = iss_valid && (iss_kind == K_READ);
  assign want_wr   = iss_valid && (iss_kind == K_WRITE_ACK);
  assign iss_stall = (want_rd && !rd_free_ok) || (want_wr && !wr_free_ok);
  assign rd_alloc  = want_rd && rd_free_ok;
  assign wr_alloc  = want_wr && wr_free_ok;

  always_comb begin
    if (iss_kind == K_READ)           iss_tag = TAG_W'(rd_free_idx);
    else if (iss_kind == K_WRITE_ACK) iss_tag = WR_BASE + TAG_W'(wr_free_idx);
    else                              iss_tag = '0;
  end

  // Response side: split the tag space between the pools.
  assign rsp_to_rd  = rsp_valid && (rsp_tag < WR_BASE);
  assign rsp_to_wr  = rsp_valid && (rsp_tag >= WR_BASE) && (rsp_tag < TAG_END);
  assign rd_rsp_idx = RD_IW'(rsp_tag);
  assign wr_rsp_idx = WR_IW'(rsp_tag - WR_BASE);
  assign rsp_retry  = (rsp_status == S_RETRY);
  assign any_known  = rd_known || wr_known;

  rt_pool #(.SLOTS(RD_SLOTS), .IDX_W(RD_IW), .CNT_W(CNT_W), .REF_W(REF_W)) u_rd_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .now       (now),
    .tmo       (tmo_cfg),
    .alloc_en  (rd_alloc),
    .alloc_ref (iss_ref),
    .free_ok   (rd_free_ok),
    .free_idx  (rd_free_idx),
    .rsp_en    (rsp_to_rd),
    .rsp_idx   (rd_rsp_idx),
    .rsp_retry (rsp_retry),
    .rsp_known (rd_known),
    .rsp_ref   (rd_rsp_ref),
    .to_fire   (rd_to_fire),
    .to_idx    (rd_to_idx),
    .to_ref    (rd_to_ref)
  );

  rt_pool #(.SLOTS(WR_SLOTS), .IDX_W(WR_IW), .CNT_W(CNT_W), .REF_W(REF_W)) u_wr_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .now       (now),
    .tmo       (tmo_cfg),
    .alloc_en  (wr_alloc),
    .alloc_ref (iss_ref),
    .free_ok   (wr_free_ok),
    .free_idx  (wr_free_idx),
    .rsp_en    (rsp_to_wr),
    .rsp_idx   (wr_rsp_idx),
    .rsp_retry (rsp_retry),
    .rsp_known (wr_known),
    .rsp_ref   (wr_rsp_ref),
    .to_fire   (wr_to_fire),
    .to_idx    (wr_to_idx),
    .to_ref    (wr_to_ref)
  );

  // Result registers: every outcome is a one-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done    <= 1'b0;
      rd_err     <= 1'b0;
      rd_data    <= '0;
      rd_ref     <= '0;
      wr_done    <= 1'b0;
      wr_err     <= 1'b0;
      wr_ref     <= '0;
      resend     <= 1'b0;
      resend_tag <= '0;
      resend_ref <= '0;
      rsp_unexp  <= 1'b0;
    end else begin
      rd_done    <= rd_known && (rsp_status == S_DONE);
      rd_err     <= (rd_known && is_failure(rsp_status)) || rd_to_fire;
      rd_data    <= (rd_known && (rsp_status == S_DONE)) ? rsp_data : '0;
      rd_ref     <= rd_known ? rd_rsp_ref : (rd_to_fire ? rd_to_ref : '0);
      wr_done    <= wr_known && (rsp_status == S_DONE);
      wr_err     <= (wr_known && is_failure(rsp_status)) || wr_to_fire;
      wr_ref     <= wr_known ? wr_rsp_ref : (wr_to_fire ? wr_to_ref : '0);
      resend     <= any_known && rsp_retry;
      resend_tag <= (any_known && rsp_retry) ? rsp_tag : '0;
      resend_ref <= (any_known && rsp_retry) ? (rd_known ? rd_rsp_ref : wr_rsp_ref) : '0;
      rsp_unexp  <= rsp_valid && !any_known;
    end
  end

  AST_POSTED_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !is_tracked(iss_kind)) |-> !iss_stall); // R2
  AST_RD_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_done && rd_err)); // R4
  AST_RESEND_NEEDS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    resend |-> $past(rsp_valid && (rsp_status == S_RETRY))); // R5
  AST_WR_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_err)); // R7
  AST_UNEXP_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unexp |-> ($past(rsp_valid) && !rd_done && !wr_done && !resend)); // R8
  AST_TAG_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    (want_rd && !iss_stall) |-> (iss_tag < WR_BASE)); // R1
endmodule

// File: tb/req_tracker_bench.sv
`timescale 1ns/1ps
module req_tracker_bench;
  localparam int NRD = 14;
  localparam int NWR = 12;
  localparam int NT  = NRD + NWR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmo_cfg = 16'd20000;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_kind = 2'd0;
  logic [7:0]  iss_ref = 8'd0;
  logic        iss_stall;
  logic [4:0]  iss_tag;
  logic        rsp_valid = 1'b0;
  logic [4:0]  rsp_tag = 5'd0;
  logic [1:0]  rsp_status = 2'd0;
  logic [31:0] rsp_data = 32'd0;
  logic        rd_done, rd_err, wr_done, wr_err, resend, rsp_unexp;
  logic [31:0] rd_data;
  logic [7:0]  rd_ref, wr_ref, resend_ref;
  logic [4:0]  resend_tag;

  int n_vec = 0;
  int n_bad = 0;

  bit       mv   [NT];
  bit [7:0] mref [NT];

  always #4 clk = ~clk;

  req_tracker u_req_tracker (
    .clk(clk), .rst_n(rst_n), .tmo_cfg(tmo_cfg),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_ref(iss_ref),
    .iss_stall(iss_stall), .iss_tag(iss_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .rd_done(rd_done), .rd_err(rd_err), .rd_data(rd_data), .rd_ref(rd_ref),
    .wr_done(wr_done), .wr_err(wr_err), .wr_ref(wr_ref),
    .resend(resend), .resend_tag(resend_tag), .resend_ref(resend_ref),
    .rsp_unexp(rsp_unexp)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench view of the pools: lowest free tag, or -1 when full.
  function automatic int model_free(input int lo, input int hi);
    for (int t = lo; t < hi; t++) if (!mv[t]) return t;
    return -1;
  endfunction

  task automatic chk_pulses(input string req, input bit e_rd_done, input bit e_rd_err,
                            input bit e_wr_done, input bit e_wr_err,
                            input bit e_resend, input bit e_unexp);
    chk(req, "rd_done", rd_done, e_rd_done);
    chk(req, "rd_err", rd_err, e_rd_err);
    chk(req, "wr_done", wr_done, e_wr_done);
    chk(req, "wr_err", wr_err, e_wr_err);
    chk(req, "resend", resend, e_resend);
    chk(req, "rsp_unexp", rsp_unexp, e_unexp);
  endtask

  task automatic next_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    iss_valid = 1'b0;
    rsp_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int t = 0; t < NT; t++) begin mv[t] = 1'b0; mref[t] = 8'd0; end
  endtask

  // Offer one request for one cycle; check stall and tag, then the quiet outputs.
  task automatic issue(input logic [1:0] kind, input logic [7:0] rf, input string req);
    int  exp_tag;
    bit  tracked;
    tracked = (kind == 2'd0) || (kind == 2'd1);
    exp_tag = (kind == 2'd0) ? model_free(0, NRD) : (kind == 2'd1) ? model_free(NRD, NT) : 0;
    iss_valid = 1'b1; iss_kind = kind; iss_ref = rf;
    #1;
    chk(req, "iss_stall", iss_stall, tracked && (exp_tag < 0));
    if (tracked && exp_tag >= 0) chk(req, "iss_tag", iss_tag, exp_tag);
    @(posedge clk);
    #1;
    iss_valid = 1'b0;
    if (tracked && exp_tag >= 0) begin mv[exp_tag] = 1'b1; mref[exp_tag] = rf; end
    chk_pulses(req, 0, 0, 0, 0, 0, 0);
  endtask

  // Present one response; predict the pulse on the following edge.
  task automatic respond(input logic [4:0] tag, input logic [1:0] st, input logic [31:0] d);
    int  t;
    bit  live, is_rd;
    t = tag;
    live  = (t < NT) && mv[t];
    is_rd = (t < NRD);
    rsp_valid = 1'b1; rsp_tag = tag; rsp_status = st; rsp_data = d;
    @(posedge clk);
    #1;
    rsp_valid = 1'b0;
    if (!live) begin
      chk_pulses("R8", 0, 0, 0, 0, 0, 1);
    end else if (st == 2'd1) begin
      chk_pulses("R5", 0, 0, 0, 0, 1, 0);
      chk("R5", "resend_tag", resend_tag, tag);
      chk("R5", "resend_ref", resend_ref, mref[t]);
    end else if (is_rd) begin
      if (st == 2'd0) begin
        chk_pulses("R4", 1, 0, 0, 0, 0, 0);
        chk("R4", "rd_data", rd_data, d);
      end else begin
        chk_pulses("R6", 0, 1, 0, 0, 0, 0);
      end
      chk("R4", "rd_ref", rd_ref, mref[t]);
      mv[t] = 1'b0;
    end else begin
      if (st == 2'd0) chk_pulses("R7", 0, 0, 1, 0, 0, 0);
      else            chk_pulses("R6", 0, 0, 0, 1, 0, 0);
      chk("R7", "wr_ref", wr_ref, mref[t]);
      mv[t] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    do_reset();

    // Reset state
    chk_pulses("R1", 0, 0, 0, 0, 0, 0);
    iss_valid = 1'b1; iss_kind = 2'd0;
    #1;
    chk("R1", "reset iss_stall", iss_stall, 1'b0);
    chk("R1", "reset iss_tag", iss_tag, 5'd0);
    iss_valid = 1'b0;

    // Simple read round trip (R4)
    issue(2'd0, 8'h11, "R4");
    respond(5'd0, 2'd0, 32'hCAFE_0001);

    // Fill the write pool; posted and streaming writes still pass (R1, R2)
    for (int i = 0; i < NWR; i++) issue(2'd1, 8'(8'h40 + i), "R1");
    issue(2'd1, 8'h99, "R1");
    issue(2'd2, 8'h55, "R2");
    issue(2'd3, 8'h56, "R2");
    repeat (4) begin next_edge(); chk_pulses("R2", 0, 0, 0, 0, 0, 0); end
    // Fill the read pool
    for (int i = 0; i < NRD; i++) issue(2'd0, 8'(8'h80 + i), "R1");
    issue(2'd0, 8'h98, "R1");

    // Unexpected tags (R8)
    respond(5'd30, 2'd0, 32'h1);
    respond(5'd27, 2'd1, 32'h2);

    // Random traffic mixed with the full pools
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 45) begin
        issue(2'($urandom_range(0, 3)), 8'($urandom), "R1");
      end else begin
        logic [4:0] tg;
        tg = 5'($urandom_range(0, 31));
        if (r < 85) begin
          for (int k = 0; k < 8; k++) begin
            if (!((int'(tg) < NT) && mv[tg])) tg = 5'($urandom_range(0, NT - 1));
          end
        end
        respond(tg, 2'($urandom_range(0, 3)), $urandom);
      end
    end

    // Exact timeout edge on a read (R3)
    do_reset();
    tmo_cfg = 16'd5;
    issue(2'd0, 8'hA1, "R3");
    for (int e = 1; e <= 5; e++) begin
      next_edge();
      if (e < 5) chk_pulses("R3", 0, 0, 0, 0, 0, 0);
      else begin chk_pulses("R3", 0, 1, 0, 0, 0, 0); chk("R3", "rd_ref", rd_ref, 8'hA1); end
    end
    mv[0] = 1'b0;
    next_edge(); chk_pulses("R3", 0, 0, 0, 0, 0, 0);

    // Retry renews the deadline (R5)
    tmo_cfg = 16'd10;
    issue(2'd0, 8'hB2, "R5");
    repeat (6) begin next_edge(); chk_pulses("R5", 0, 0, 0, 0, 0, 0); end
    respond(5'd0, 2'd1, 32'h0);
    for (int e = 1; e <= 10; e++) begin
      next_edge();
      if (e < 10) chk_pulses("R5", 0, 0, 0, 0, 0, 0);
      else begin chk_pulses("R5", 0, 1, 0, 0, 0, 0); chk("R5", "rd_ref", rd_ref, 8'hB2); end
    end
    mv[0] = 1'b0;

    // Write timeout (R3)
    tmo_cfg = 16'd3;
    issue(2'd1, 8'hC3, "R3");
    for (int e = 1; e <= 3; e++) begin
      next_edge();
      if (e < 3) chk_pulses("R3", 0, 0, 0, 0, 0, 0);
      else begin chk_pulses("R3", 0, 0, 0, 1, 0, 0); chk("R3", "wr_ref", wr_ref, 8'hC3); end
    end
    mv[NRD] = 1'b0;

    // Two reads due in the same cycle: lowest tag first, one per cycle (R9)
    tmo_cfg = 16'd6;
    issue(2'd0, 8'hD0, "R9");
    tmo_cfg = 16'd5;
    issue(2'd0, 8'hD1, "R9");
    for (int e = 1; e <= 6; e++) begin
      next_edge();
      if (e < 5) chk_pulses("R9", 0, 0, 0, 0, 0, 0);
      else if (e == 5) begin chk_pulses("R9", 0, 1, 0, 0, 0, 0); chk("R9", "first rd_ref", rd_ref, 8'hD0); end
      else begin chk_pulses("R9", 0, 1, 0, 0, 0, 0); chk("R9", "second rd_ref", rd_ref, 8'hD1); end
    end
    mv[0] = 1'b0; mv[1] = 1'b0;
    next_edge(); chk_pulses("R9", 0, 0, 0, 0, 0, 0);

    // Response to a timed-out tag is now unexpected (R8)
    respond(5'd1, 2'd0, 32'h7);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule